// File: doc/BRIEF.md
# SDRAM Command Bus Bank-State Monitor

This block is a passive observer on the command bus of a four-bank synchronous DRAM. On every clock edge it decodes the chip-select, row strobe, column strobe and write-enable lines into a command. It also reads the clock-enable line, the two bank-select bits and address bit 10. From these it keeps a model of what each bank is doing and of the device-wide power condition. Any command that the current state forbids, or that comes before a minimum clock gap has passed, produces a one-cycle error pulse. The pulse carries a 4-bit code and the number of the bank at fault.

The monitor never drives the bus. It sits beside a memory controller, in simulation or in silicon, and catches protocol faults at their source. The per-bank states and the power state are exposed as outputs so that a scoreboard or a debug probe can follow the device model. The minimum gaps (activate to column command, precharge to activate, refresh cycle, activate to activate) and the burst length are parameters counted in clock cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With chip-select low, the strobe triple {ras_n,cas_n,we_n} decodes as follows: 111 no-op, 110 burst stop, 101 read, 100 write, 011 activate, 010 precharge, 001 refresh, 000 mode set. Chip-select high is a deselect, and it has no effect whatever the other lines show.
- R2: An activate to an idle bank moves the bank to opening (1). The bank becomes open (2) T_RCD cycles after the activate. A read, write or precharge to an opening bank is reported with code 4.
- R3: A read or write to an open bank starts a burst lasting BURST_LEN cycles, after which the bank is open again. The burst state is reading (3) or writing (4) when a10 is low, and reading with auto-close (5) or writing with auto-close (6) when a10 is high. An auto-close burst goes to closing (7) at its end.
- R4: A read, write or precharge to the same bank during a plain burst ends that burst and takes effect at once. A burst stop returns every bank in a plain burst to open.
- R5: A read, write, activate or precharge that reaches a bank in an auto-close burst is reported with code 3.
- R6: A precharge with a10 low closes only the bank selected by ba. With a10 high it closes every bank. A closing bank is idle T_RP cycles after the precharge. An activate, read or write to a closing bank is reported with code 5.
- R7: A read or write to an idle bank, or an activate to a bank that is opening, open or in a plain burst, is reported with code 1.
- R8: A refresh or mode set while any bank is not idle is reported with code 2. A refresh puts all banks into refreshing (8) for T_RC cycles. Any command other than no-op or deselect during that time is reported with code 6.
- R9: An activate fewer than T_RRD cycles after the previous accepted activate is reported with code 7.
- R10: Errors appear one cycle after the offending command as a single-cycle err_pulse with err_code and err_bank. err_bank is the command's bank field; for a precharge to all banks it is the lowest failing bank. A command that raises an error changes no state.
- R11: With all banks idle, clke high in the previous cycle and low in this one, a no-op or deselect enters power-down (pwr_state 1) and a refresh enters self-refresh (pwr_state 2). No bank changes state. Any other command is reported with code 9 and nothing is entered.
- R12: In power-down or self-refresh, the state is held while clke stays low. A cycle with clke high returns pwr_state to 0. If that cycle carries anything other than no-op or deselect, the monitor reports code 8 and does not apply the command.
- R13: Outside the low-power states, a low clke suspends the following cycle. The command in that cycle is ignored and no timer advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clke | input | 1 | Clock-enable line of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W (2) | Bank-select bits |
| a10 | input | 1 | Address bit 10 (auto-close / all-banks) |
| err_pulse | output | 1 | One-cycle error flag |
| err_code | output | 4 | Error class of the flagged command |
| err_bank | output | BA_W (2) | Bank blamed for the error |
| bank_state | output | 4*NUM_BANKS | State of bank i in bits [4i+3:4i] |
| pwr_state | output | 2 | 0 running, 1 power-down, 2 self-refresh |

## Verification
Each command class is sent to banks in every state it can meet. The legal cases show that the state model advances with the right cycle counts. The illegal ones show that each error code is raised in exactly its own situation. Gap checks are probed one cycle short of the limit and again at the limit, which separates an off-by-one counter from a correct one. Clock-enable patterns cover suspension with busy banks, entry and exit of both low-power states, and entry attempts with a forbidden command. Together these show that an ignored or rejected command leaves the bank states untouched.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    BS_IDLE = 4'd0, BS_OPENING = 4'd1, BS_OPEN = 4'd2, BS_RD = 4'd3, BS_WR = 4'd4,
    BS_RD_AC = 4'd5, BS_WR_AC = 4'd6, BS_CLOSING = 4'd7, BS_REFR = 4'd8
  } bank_st_e;

  typedef enum logic [3:0] {
    C_DESEL, C_NOP, C_STOP, C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MODE
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE = 4'd0, E_STATE = 4'd1, E_NOTIDLE = 4'd2, E_ACLOCK = 4'd3, E_RCD = 4'd4,
    E_RP = 4'd5, E_RC = 4'd6, E_RRD = 4'd7, E_WAKE = 4'd8, E_SLEEP = 4'd9
  } err_e;

  typedef enum logic [1:0] {PW_RUN = 2'd0, PW_DOWN = 2'd1, PW_SELF = 2'd2} pwr_e;
endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output cmd_e            cmd,
  output logic            quiet,
  output logic [NUM_BANKS-1:0] hit
);
  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b110:  cmd = C_STOP;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b011:  cmd = C_ACT;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        default: cmd = C_MODE;
      endcase
    end
  end

  assign quiet = (cmd == C_DESEL) || (cmd == C_NOP);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
    logic sel;
    assign sel = (ba == BA_W'(g));
    assign hit[g] = ((cmd == C_RD || cmd == C_WR || cmd == C_ACT) && sel) ||
                    (cmd == C_PRE && (a10 || sel)) ||
                    (cmd == C_REF) || (cmd == C_STOP);
  end
endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 6,
  parameter int BURST_LEN = 4,
  localparam int M1 = (T_RCD > T_RP) ? T_RCD : T_RP,
  localparam int M2 = (M1 > T_RC) ? M1 : T_RC,
  localparam int M3 = (M2 > BURST_LEN) ? M2 : BURST_LEN,
  localparam int CW = $clog2(M3 + 1)
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     take,
  input  logic     hit,
  input  cmd_e     cmd,
  input  logic     ac,
  output bank_st_e st,
  output logic     berr,
  output err_e     bcode
);
  localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
  localparam logic [CW-1:0] RC_LD  = CW'(T_RC - 1);
  localparam logic [CW-1:0] BL_LD  = CW'(BURST_LEN - 1);

  bank_st_e      nst;
  logic [CW-1:0] cnt, ncnt;
  logic          timed, busy_ok;

  assign timed   = (st != BS_IDLE) && (st != BS_OPEN);
  assign busy_ok = (st == BS_OPEN) || (st == BS_RD) || (st == BS_WR);

  always_comb begin
    bcode = E_NONE;
    if (hit) begin
      case (cmd)
        C_RD, C_WR: case (st)
          BS_IDLE:            bcode = E_STATE;
          BS_OPENING:         bcode = E_RCD;
          BS_CLOSING:         bcode = E_RP;
          BS_RD_AC, BS_WR_AC: bcode = E_ACLOCK;
          default:            bcode = E_NONE;
        endcase
        C_ACT: case (st)
          BS_OPENING, BS_OPEN, BS_RD, BS_WR: bcode = E_STATE;
          BS_CLOSING:                        bcode = E_RP;
          BS_RD_AC, BS_WR_AC:                bcode = E_ACLOCK;
          default:                           bcode = E_NONE;
        endcase
        C_PRE: case (st)
          BS_OPENING:         bcode = E_RCD;
          BS_RD_AC, BS_WR_AC: bcode = E_ACLOCK;
          default:            bcode = E_NONE;
        endcase
        default: bcode = E_NONE;
      endcase
    end
    berr = (bcode != E_NONE);
  end

  always_comb begin
    nst  = st;
    ncnt = cnt;
    if (tick) begin
      if (timed) begin
        if (cnt == CW'(1)) begin
          ncnt = '0;
          case (st)
            BS_RD_AC, BS_WR_AC: begin
              nst  = (T_RP > 1) ? BS_CLOSING : BS_IDLE;
              ncnt = RP_LD;
            end
            BS_OPENING, BS_RD, BS_WR: nst = BS_OPEN;
            default:                  nst = BS_IDLE;
          endcase
        end else begin
          ncnt = cnt - CW'(1);
        end
      end
      if (take && hit) begin
        case (cmd)
          C_ACT: if (st == BS_IDLE) begin
            nst  = (T_RCD > 1) ? BS_OPENING : BS_OPEN;
            ncnt = RCD_LD;
          end
          C_RD, C_WR: if (busy_ok) begin
            ncnt = BL_LD;
            if (BURST_LEN > 1) begin
              if (cmd == C_RD) nst = ac ? BS_RD_AC : BS_RD;
              else             nst = ac ? BS_WR_AC : BS_WR;
            end else if (ac) begin
              nst  = (T_RP > 1) ? BS_CLOSING : BS_IDLE;
              ncnt = RP_LD;
            end else begin
              nst = BS_OPEN;
            end
          end
          C_PRE: if (busy_ok) begin
            nst  = (T_RP > 1) ? BS_CLOSING : BS_IDLE;
            ncnt = RP_LD;
          end
          C_STOP: if (st == BS_RD || st == BS_WR) begin
            nst  = BS_OPEN;
            ncnt = '0;
          end
          C_REF: if (st == BS_IDLE) begin
            nst  = (T_RC > 1) ? BS_REFR : BS_IDLE;
            ncnt = RC_LD;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= BS_IDLE;
      cnt <= '0;
    end else begin
      st  <= nst;
      cnt <= ncnt;
    end
  end

  AST_OPEN_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == BS_OPEN) |=> (st != BS_IDLE)); // R6

  AST_AC_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (st == BS_RD_AC || st == BS_WR_AC) |=>
      (st == $past(st) || st == BS_CLOSING || st == BS_IDLE)); // R5
endmodule

// File: rtl/sdram_mon_pwr.sv
module sdram_mon_pwr
  import sdram_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clke,
  input  cmd_e cmd,
  input  logic quiet,
  input  logic all_idle,
  output pwr_e pwr,
  output logic en,
  output logic hold,
  output logic entry,
  output logic err_entry,
  output logic err_exit
);
  logic clke_q;

  assign en        = (pwr == PW_RUN) && clke_q;
  assign hold      = (pwr == PW_RUN) && !clke_q;
  assign entry     = en && !clke && all_idle;
  assign err_entry = entry && !(quiet || cmd == C_REF);
  assign err_exit  = (pwr != PW_RUN) && clke && !quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr    <= PW_RUN;
      clke_q <= 1'b1;
    end else begin
      clke_q <= clke;
      case (pwr)
        PW_RUN: begin
          if (entry && quiet)             pwr <= PW_DOWN;
          else if (entry && cmd == C_REF) pwr <= PW_SELF;
        end
        default: if (clke) pwr <= PW_RUN;
      endcase
    end
  end

  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (rst)
    (pwr != PW_RUN && clke) |=> (pwr == PW_RUN)); // R12
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 6,
  parameter int T_RRD     = 2,
  parameter int BURST_LEN = 4,
  localparam int BA_W = $clog2(NUM_BANKS),
  localparam int RW   = $clog2(T_RRD + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic                   a10,
  output logic                   err_pulse,
  output logic [3:0]             err_code,
  output logic [BA_W-1:0]        err_bank,
  output logic [4*NUM_BANKS-1:0] bank_state,
  output logic [1:0]             pwr_state
);
  cmd_e                 cmd;
  logic                 quiet;
  logic [NUM_BANKS-1:0] hit, berr;
  bank_st_e             st    [NUM_BANKS];
  err_e                 bcode [NUM_BANKS];
  logic                 all_idle, any_refr, all_refr;
  pwr_e                 pwr;
  logic                 en, hold, entry, err_entry, err_exit, take;
  err_e                 e_code;
  logic [BA_W-1:0]      e_bank;
  logic [RW-1:0]        rrd_cnt;

  sdram_mon_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a10(a10), .cmd(cmd), .quiet(quiet), .hit(hit)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_mon_bank #(
      .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk(clk), .rst(rst), .tick(en), .take(take), .hit(hit[g]),
      .cmd(cmd), .ac(a10), .st(st[g]), .berr(berr[g]), .bcode(bcode[g])
    );
    assign bank_state[4*g +: 4] = st[g];
  end

  always_comb begin
    all_idle = 1'b1;
    any_refr = 1'b0;
    all_refr = 1'b1;
    for (int i = 0; i < NUM_BANKS; i++) begin
      all_idle = all_idle & (st[i] == BS_IDLE);
      any_refr = any_refr | (st[i] == BS_REFR);
      all_refr = all_refr & (st[i] == BS_REFR);
    end
  end

  sdram_mon_pwr u_pwr (
    .clk(clk), .rst(rst), .clke(clke), .cmd(cmd), .quiet(quiet),
    .all_idle(all_idle), .pwr(pwr), .en(en), .hold(hold), .entry(entry),
    .err_entry(err_entry), .err_exit(err_exit)
  );

  always_comb begin
    e_code = E_NONE;
    e_bank = ba;
    if (err_exit) e_code = E_WAKE;
    else if (en) begin
      if (any_refr && !quiet)                               e_code = E_RC;
      else if ((cmd == C_REF || cmd == C_MODE) && !all_idle) e_code = E_NOTIDLE;
      else if (err_entry)                                   e_code = E_SLEEP;
      else if (|berr) begin
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
          if (berr[i]) begin
            e_code = bcode[i];
            e_bank = BA_W'(i);
          end
        end
      end
      else if (cmd == C_ACT && rrd_cnt != '0)               e_code = E_RRD;
    end
  end

  assign take = en && !entry && (e_code == E_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_cnt   <= '0;
      err_pulse <= 1'b0;
      err_code  <= 4'd0;
      err_bank  <= '0;
    end else begin
      if (take && cmd == C_ACT)    rrd_cnt <= RW'(T_RRD - 1);
      else if (en && rrd_cnt != '0) rrd_cnt <= rrd_cnt - RW'(1);
      err_pulse <= (e_code != E_NONE);
      err_code  <= e_code;
      err_bank  <= e_bank;
    end
  end

  assign pwr_state = pwr;

  AST_SLEEP_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    (pwr != PW_RUN) |-> all_idle); // R11

  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(bank_state) && !err_pulse)); // R13

  AST_REFRESH_ALL: assert property (@(posedge clk) disable iff (rst)
    any_refr |-> all_refr); // R8
endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] K_NOP = 4'b0111, K_DES = 4'b1000, K_STOP = 4'b0110,
                         K_RD = 4'b0101, K_WR = 4'b0100, K_ACT = 4'b0011,
                         K_PRE = 4'b0010, K_REF = 4'b0001, K_MODE = 4'b0000;

  logic clk = 1'b0, rst = 1'b1, clke = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic err_pulse;
  logic [3:0] err_code;
  logic [1:0] err_bank, pwr_state;
  logic [15:0] bank_state;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor uut (
    .clk(clk), .rst(rst), .clke(clke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err_pulse(err_pulse), .err_code(err_code),
    .err_bank(err_bank), .bank_state(bank_state), .pwr_state(pwr_state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bst(input int b);
    return int'(bank_state[4*b +: 4]);
  endfunction

  task automatic step(input logic [3:0] k, input int b, input logic ac, input logic ck);
    {cs_n, ras_n, cas_n, we_n} = k;
    ba = 2'(b); a10 = ac; clke = ck;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) step(K_NOP, 0, 1'b0, 1'b1);
  endtask

  task automatic chk_err(input string req, input int code, input int bank);
    check({req, " err_pulse"}, int'(err_pulse), (code != 0) ? 1 : 0);
    check({req, " err_code"}, int'(err_code), code);
    if (code != 0) check({req, " err_bank"}, int'(err_bank), bank);
  endtask

  task automatic t_activate;
    step(K_ACT, 0, 0, 1); check("R2 opening", bst(0), 1); chk_err("R2", 0, 0);
    step(K_RD, 0, 0, 1);  chk_err("R2 read too early", 4, 0); check("R10 unchanged", bst(0), 1);
    nops(1);              check("R2 open after tRCD", bst(0), 2); chk_err("R10 single pulse", 0, 0);
    step(K_DES, 0, 0, 1); check("R1 deselect no effect", bst(0), 2); chk_err("R1", 0, 0);
    step(K_PRE, 0, 0, 1); check("R6 closing", bst(0), 7);
    nops(2);              check("R6 idle after tRP", bst(0), 0);
  endtask

  task automatic t_burst;
    step(K_ACT, 0, 0, 1); nops(2);
    step(K_RD, 0, 0, 1); check("R3 reading", bst(0), 3); chk_err("R3", 0, 0);
    nops(2);             check("R3 still reading", bst(0), 3);
    nops(1);             check("R3 burst end open", bst(0), 2);
    step(K_WR, 0, 1, 1); check("R3 write auto-close", bst(0), 6);
    nops(3);             check("R3 auto-close to closing", bst(0), 7);
    nops(2);             check("R3 idle after auto-close", bst(0), 0);
  endtask

  task automatic t_autoclose;
    step(K_ACT, 1, 0, 1); nops(2);
    step(K_RD, 1, 1, 1);  check("R3 read auto-close", bst(1), 5);
    step(K_RD, 1, 0, 1);  chk_err("R5 read into locked", 3, 1); check("R5 state", bst(1), 5);
    step(K_PRE, 1, 0, 1); chk_err("R5 precharge into locked", 3, 1);
    nops(1);              check("R5 burst completed", bst(1), 7);
    step(K_ACT, 1, 0, 1); chk_err("R6 activate while closing", 5, 1); check("R6 state", bst(1), 7);
    nops(1);              check("R6 idle", bst(1), 0);
  endtask

  task automatic t_interrupt;
    step(K_ACT, 2, 0, 1); nops(2);
    step(K_RD, 2, 0, 1);  check("R4 reading", bst(2), 3);
    step(K_WR, 2, 0, 1);  check("R4 write cuts read", bst(2), 4); chk_err("R4", 0, 0);
    step(K_PRE, 2, 0, 1); check("R4 precharge cuts write", bst(2), 7); chk_err("R4", 0, 0);
    nops(2);
    step(K_ACT, 2, 0, 1); nops(2);
    step(K_RD, 2, 0, 1);
    step(K_STOP, 0, 0, 1); check("R4 burst stop", bst(2), 2); chk_err("R4 stop", 0, 0);
    step(K_PRE, 2, 0, 1); nops(2);
  endtask

  task automatic t_precharge_all;
    step(K_ACT, 2, 0, 1); nops(1);
    step(K_ACT, 3, 0, 1); nops(2);
    check("R6 b2 open", bst(2), 2); check("R6 b3 open", bst(3), 2);
    step(K_PRE, 0, 1, 1);
    check("R6 all b2", bst(2), 7); check("R6 all b3", bst(3), 7); check("R6 b0 idle", bst(0), 0);
    chk_err("R6", 0, 0);
    nops(2); check("R6 all idle", int'(bank_state), 0);
  endtask

  task automatic t_illegal;
    step(K_RD, 0, 0, 1);  chk_err("R7 read idle", 1, 0); check("R7 state", bst(0), 0);
    step(K_ACT, 0, 0, 1); nops(2);
    step(K_ACT, 0, 0, 1); chk_err("R7 activate open", 1, 0); check("R7 still open", bst(0), 2);
    step(K_PRE, 0, 0, 1); nops(2);
  endtask

  task automatic t_rrd;
    step(K_ACT, 0, 0, 1);
    step(K_ACT, 1, 0, 1); chk_err("R9 activate gap", 7, 1); check("R9 b1 idle", bst(1), 0);
    step(K_ACT, 1, 0, 1); chk_err("R9 gap met", 0, 0); check("R9 b1 opening", bst(1), 1);
    nops(2);
    step(K_PRE, 0, 1, 1); nops(2);
  endtask

  task automatic t_refresh;
    step(K_ACT, 0, 0, 1); nops(1);
    step(K_REF, 0, 0, 1); chk_err("R8 refresh not idle", 2, 0); check("R8 unchanged", bst(0), 2);
    nops(1); step(K_PRE, 0, 0, 1); nops(2);
    step(K_REF, 0, 0, 1); check("R8 refreshing", int'(bank_state), 16'h8888);
    step(K_MODE, 0, 0, 1); chk_err("R8 mode during refresh", 6, 0);
    nops(3);              check("R8 still refreshing", int'(bank_state), 16'h8888);
    nops(1);              check("R8 idle after tRC", int'(bank_state), 0);
    step(K_MODE, 0, 0, 1); chk_err("R8 mode set idle", 0, 0);
  endtask

  task automatic t_suspend;
    step(K_ACT, 0, 0, 1);
    step(K_NOP, 0, 0, 0); check("R13 no power-down while busy", int'(pwr_state), 0);
    step(K_RD, 0, 0, 1);  check("R13 suspended state", bst(0), 1); chk_err("R13 ignored", 0, 0);
    nops(1);              check("R13 resumed timer", bst(0), 2);
    step(K_PRE, 0, 0, 1); nops(2);
  endtask

  task automatic t_power;
    step(K_NOP, 0, 0, 0); check("R11 power-down", int'(pwr_state), 1);
    step(K_NOP, 0, 0, 0); check("R12 hold", int'(pwr_state), 1);
    step(K_NOP, 0, 0, 1); check("R12 exit", int'(pwr_state), 0); chk_err("R12", 0, 0);
    step(K_REF, 0, 0, 0); check("R11 self-refresh", int'(pwr_state), 2);
    check("R11 banks idle", int'(bank_state), 0);
    step(K_NOP, 0, 0, 0); check("R12 hold self", int'(pwr_state), 2);
    step(K_ACT, 0, 0, 1); chk_err("R12 bad exit", 8, 0);
    check("R12 exited", int'(pwr_state), 0); check("R12 not applied", bst(0), 0);
    step(K_ACT, 1, 0, 0); chk_err("R11 bad entry", 9, 1);
    check("R11 not entered", int'(pwr_state), 0); check("R11 not applied", bst(1), 0);
    nops(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset err", int'(err_pulse), 0);
    check("R10 reset states", int'(bank_state), 0);
    check("R11 reset power", int'(pwr_state), 0);
    rst = 1'b0;
    nops(2);
    t_activate();
    t_burst();
    t_autoclose();
    t_interrupt();
    t_precharge_all();
    t_illegal();
    t_rrd();
    t_refresh();
    t_suspend();
    t_power();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule